// File: doc/BRIEF.md
# Auto-Incrementing Indirect Memory Access Port

This block gives a byte-wide host I/O bus indirect access to a local Flash/SRAM bus. The host first loads a 15-bit local address through two byte registers. It then reads or writes through any one of a group of data-port addresses. Each data-port access runs one cycle on the local memory bus at that address, with two externally supplied bank bits placed above it. When the memory signals ready, the access completes and the address steps forward by one. A stream of bytes can therefore be moved with no further address writes.

The top bit of the upper address register is a power-down control. In ISA mode, writing it with 1 raises a level interrupt to an embedded controller. Reading it reports whether the controller has put the device into power down. Writing 0 while powered down sends a one-cycle wake request. The address counter has no reset and keeps its value through any reset.

Top module: `idx_mem_port`

## Requirements
- R1: Host address 0 is the low address byte (bits [7:0]) and host address 1 holds bits [14:8] in its bits [6:0]. A host write loads the byte in the same clock edge, and a host read returns it in the same cycle.
- R2: A host read at a data-port address (host_addr 4..7, top address bit set) asserts mem_rd. It drives mem_addr = {bank_sel, address}, returns mem_rdata on host_rdata and reports host_done equal to mem_ready.
- R3: A host write at a data-port address asserts mem_wr, drives host_wdata onto mem_wdata at mem_addr = {bank_sel, address}, and reports host_done equal to mem_ready.
- R4: Each data-port access that completes (mem_ready high) increments the 15-bit address by one at that clock edge. The upper byte advances only when the low byte rolls over from 0xFF. An access with mem_ready low leaves the address unchanged.
- R5: The address wraps from 0x7FFF to 0x0000, and mem_addr[16:15] always follows bank_sel.
- R6: All four data-port addresses use the one shared address and add no offset.
- R7: The address registers keep their contents through reset.
- R8: With isa_mode high, writing 1 to bit 7 of host address 1 sets pd_irq at the next edge. pd_irq stays set until pd_irq_ack is seen, and it is 0 after reset.
- R9: With isa_mode high, bit 7 of a read of host address 1 equals pd_status.
- R10: With isa_mode high and pd_status high, writing 0 to bit 7 of host address 1 produces a one-cycle pd_wake pulse after that edge.
- R11: With isa_mode low, writes to bit 7 of host address 1 set neither pd_irq nor pd_wake, and that bit reads 0.
- R12: mem_rd and mem_wr are never both high, and neither is high without a data-port request. A register access reports host_done in the same cycle, and reads of host addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Host access request, one access per cycle it is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Host register/port select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_done | output | 1 | Access completes this cycle |
| bank_sel | input | 2 | Bank bits placed on mem_addr[16:15] |
| isa_mode | input | 1 | Enables the power-down control bit |
| mem_addr | output | 17 | Local memory address |
| mem_rd | output | 1 | Local memory read strobe |
| mem_wr | output | 1 | Local memory write strobe |
| mem_wdata | output | 8 | Local memory write data |
| mem_rdata | input | 8 | Local memory read data |
| mem_ready | input | 1 | Local memory cycle done |
| pd_status | input | 1 | Controller reports device powered down |
| pd_irq_ack | input | 1 | Controller clears the power-down interrupt |
| pd_irq | output | 1 | Power-down request interrupt (level) |
| pd_wake | output | 1 | One-cycle power-down exit request |

## Verification
The assertions assume that host_req, host_we and host_addr are steady across a clock edge. They also assume that the address has been loaded by the host before its increment is judged, since the counter has no reset value. The stimulus changes every input only on the falling clock edge and writes both address bytes before the first data-port access. The bench's reference model treats the address as unknown until both bytes are written.

// File: rtl/idx_port_pkg.sv
// Package: shared types for the indirect memory access port.
// Assumes: one host access target is decoded per cycle.
package idx_port_pkg;
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_DP   = 2'd3
    } tgt_e;
endpackage

// File: rtl/idx_port_decode.sv
// Module: decodes a host request into its target register or data port.
// Assumes: the data ports fill the upper half of the host address space.
module idx_port_decode
    import idx_port_pkg::*;
#(
    parameter int HA_W = 3
) (
    input  logic            host_req,
    input  logic [HA_W-1:0] host_addr,
    output tgt_e            tgt
);
    // Pick the addressed target; reserved addresses map to none.
    always_comb begin
        if (!host_req)
            tgt = TGT_NONE;
        else if (host_addr[HA_W-1])
            tgt = TGT_DP;
        else if (host_addr == HA_W'(0))
            tgt = TGT_LO;
        else if (host_addr == HA_W'(1))
            tgt = TGT_HI;
        else
            tgt = TGT_NONE;
    end
endmodule

// File: rtl/idx_port_addr_ctr.sv
// Module: split local address counter, written bytewise and stepped by one.
// Assumes: no reset on purpose; the contents survive every reset.
// A byte write takes precedence over a step in the same cycle.
module idx_port_addr_ctr #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    output logic [ADDR_W-1:0] addr_q
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              lo_carry;

    // Carry out of the low byte when it is about to roll over.
    assign lo_carry = &lo_q;

    // Low byte: host write, else step.
    always_ff @(posedge clk) begin
        if (wr_lo)
            lo_q <= wdata;
        else if (step)
            lo_q <= lo_q + 1'b1;
    end

    // High bits: host write, else advance on low-byte carry.
    always_ff @(posedge clk) begin
        if (wr_hi)
            hi_q <= wdata[HI_W-1:0];
        else if (step && lo_carry)
            hi_q <= hi_q + 1'b1;
    end

    assign addr_q = {hi_q, lo_q};
endmodule

// File: rtl/idx_port_pwr.sv
// Module: power-down request/acknowledge bit handling.
// Assumes: the controller holds pd_status while powered down and
// pulses or holds pd_irq_ack to clear the request.
module idx_port_pwr (
    input  logic clk,
    input  logic rst_n,
    input  logic isa_mode,
    input  logic wr_hi,
    input  logic wr_bit,
    input  logic pd_status,
    input  logic pd_irq_ack,
    output logic pd_irq,
    output logic pd_wake,
    output logic rd_bit
);
    logic set_req;
    logic exit_req;

    // Qualified host actions on the control bit.
    assign set_req  = wr_hi && isa_mode && wr_bit;
    assign exit_req = wr_hi && isa_mode && !wr_bit && pd_status;

    // Interrupt level: set by request, held until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_irq <= 1'b0;
        else if (set_req)
            pd_irq <= 1'b1;
        else if (pd_irq_ack)
            pd_irq <= 1'b0;
    end

    // Wake request: single-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pd_wake <= 1'b0;
        else
            pd_wake <= exit_req;
    end

    // Read-back of the control bit.
    assign rd_bit = isa_mode && pd_status;
endmodule

// File: rtl/idx_mem_port.sv
// Module: top of the indirect memory access port. It decodes host
// accesses, drives the local memory strobes, merges the bank bits and
// returns read data.
// Assumes: ADDR_W = 2*DATA_W-1, so the upper register is one control
// bit above the high address bits; NUM_DP is a power of two.
module idx_mem_port
    import idx_port_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int BANK_W = 2,
    parameter int NUM_DP = 4,
    localparam int HA_W  = $clog2(2 * NUM_DP),
    localparam int MA_W  = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [HA_W-1:0]   host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              isa_mode,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    input  logic              pd_status,
    input  logic              pd_irq_ack,
    output logic              pd_irq,
    output logic              pd_wake
);
    tgt_e              tgt;
    logic              addr_wr;
    logic              wr_lo;
    logic              wr_hi;
    logic              step;
    logic              pd_rd_bit;
    logic [ADDR_W-1:0] addr_q;

    idx_port_decode #(.HA_W(HA_W)) u_dec (
        .host_req  (host_req),
        .host_addr (host_addr),
        .tgt       (tgt)
    );

    // Register writes and completed data-port accesses.
    assign wr_lo   = host_we && (tgt == TGT_LO);
    assign wr_hi   = host_we && (tgt == TGT_HI);
    assign addr_wr = wr_lo || wr_hi;
    assign step    = (tgt == TGT_DP) && mem_ready;

    idx_port_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctr (
        .clk    (clk),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (host_wdata),
        .step   (step),
        .addr_q (addr_q)
    );

    idx_port_pwr u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .isa_mode   (isa_mode),
        .wr_hi      (wr_hi),
        .wr_bit     (host_wdata[DATA_W-1]),
        .pd_status  (pd_status),
        .pd_irq_ack (pd_irq_ack),
        .pd_irq     (pd_irq),
        .pd_wake    (pd_wake),
        .rd_bit     (pd_rd_bit)
    );

    // Local memory cycle: strobes, merged address and write data.
    assign mem_rd    = (tgt == TGT_DP) && !host_we;
    assign mem_wr    = (tgt == TGT_DP) && host_we;
    assign mem_addr  = {bank_sel, addr_q};
    assign mem_wdata = host_wdata;

    // Host read mux.
    always_comb begin
        case (tgt)
            TGT_LO:  host_rdata = addr_q[DATA_W-1:0];
            TGT_HI:  host_rdata = {pd_rd_bit, addr_q[ADDR_W-1:DATA_W]};
            TGT_DP:  host_rdata = mem_rdata;
            default: host_rdata = '0;
        endcase
    end

    // Completion: registers at once, data ports on memory ready.
    assign host_done = (tgt == TGT_DP) ? mem_ready : host_req;
endmodule

// File: rtl/idx_mem_port_chk.sv
// Checker: temporal properties of the indirect memory access port.
// Assumes: inputs are stable across the sampling edge.
module idx_mem_port_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              step,
    input logic              addr_wr,
    input logic [ADDR_W-1:0] addr_q,
    input logic              pd_irq,
    input logic              pd_irq_ack,
    input logic              isa_mode
);
    assert_incr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !addr_wr && !$isunknown(addr_q))
            |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !addr_wr) |=> $stable(addr_q));

    assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_req |-> (!mem_rd && !mem_wr));

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_irq && !pd_irq_ack) |=> pd_irq);

    assert_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!isa_mode && !pd_irq) |=> !pd_irq);
endmodule

bind idx_mem_port idx_mem_port_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .step       (step),
    .addr_wr    (addr_wr),
    .addr_q     (addr_q),
    .pd_irq     (pd_irq),
    .pd_irq_ack (pd_irq_ack),
    .isa_mode   (isa_mode)
);

// File: tb/idx_mem_port_tb.sv
module idx_mem_port_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_req, host_we;
    logic [2:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        host_done;
    logic [1:0]  bank_sel;
    logic        isa_mode;
    logic [16:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready, pd_status, pd_irq_ack, pd_irq, pd_wake;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // Reference model state.
    int  m_addr;
    bit  m_lo_known = 0, m_hi_known = 0;
    bit  m_irq = 0, m_wake = 0;
    logic [7:0] last_rdata;

    always #5 clk = ~clk;

    idx_mem_port u_dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // One clock: compare outputs against the model, then advance it.
    task automatic cycle();
        bit dp;
        #2;
        dp = host_req && host_addr[2];
        last_rdata = host_rdata;
        chk("R8 pd_irq", pd_irq, m_irq);
        chk("R10 pd_wake", pd_wake, m_wake);
        chk("R12 mem_rd", mem_rd, dp && !host_we);
        chk("R3 mem_wr", mem_wr, dp && host_we);
        chk("R12 host_done", host_done, dp ? mem_ready : host_req);
        if (dp && m_lo_known && m_hi_known)
            chk("R2 mem_addr", mem_addr, {bank_sel, m_addr[14:0]});
        if (dp && host_we) chk("R3 mem_wdata", mem_wdata, host_wdata);
        if (host_req && !host_we) begin
            if (dp) chk("R2 rdata", host_rdata, mem_rdata);
            else if (host_addr == 0 && m_lo_known)
                chk("R1 low", host_rdata, m_addr & 8'hFF);
            else if (host_addr == 1) begin
                if (m_hi_known) chk("R1 high", host_rdata[6:0], (m_addr >> 8) & 7'h7F);
                if (isa_mode) chk("R9 pd bit", host_rdata[7], pd_status);
                else          chk("R11 pd bit", host_rdata[7], 0);
            end else if (host_addr >= 2)
                chk("R12 reserved", host_rdata, 0);
        end
        @(posedge clk);
        if (host_req && host_we && host_addr == 0) begin
            m_addr = (m_addr & 32'h7F00) | host_wdata; m_lo_known = 1;
        end else if (host_req && host_we && host_addr == 1) begin
            m_addr = (m_addr & 32'hFF) | ((host_wdata & 8'h7F) << 8); m_hi_known = 1;
        end else if (dp && mem_ready)
            m_addr = (m_addr + 1) & 32'h7FFF;
        if (!rst_n) begin
            m_irq = 0; m_wake = 0;
        end else begin
            bit hw;
            hw = host_req && host_we && host_addr == 1 && isa_mode;
            m_wake = hw && !host_wdata[7] && pd_status;
            if (hw && host_wdata[7]) m_irq = 1;
            else if (pd_irq_ack) m_irq = 0;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
        cycle();
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
        cycle();
    endtask

    task automatic rd_reg(input logic [2:0] a);
        host_req = 1; host_we = 0; host_addr = a;
        cycle();
    endtask

    task automatic dp_acc(input logic [2:0] a, input bit we, input logic [7:0] d,
                          input bit rdy);
        host_req = 1; host_we = we; host_addr = a; host_wdata = d;
        mem_ready = rdy; mem_rdata = d ^ 8'h5A;
        cycle();
        mem_ready = 0;
    endtask

    // Address read back through the host registers, expected value given.
    task automatic expect_addr(input string tag, input int val);
        rd_reg(0); chk(tag, last_rdata, val & 8'hFF);
        rd_reg(1); chk(tag, last_rdata[6:0], (val >> 8) & 7'h7F);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 0; host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
        bank_sel = 2'd3; isa_mode = 0; mem_rdata = 0; mem_ready = 0;
        pd_status = 0; pd_irq_ack = 0;
        @(posedge clk); @(negedge clk);
        idle(); idle();
        chk("R8 reset irq", pd_irq, 0);
        rst_n = 1;
        // R1: register load and read back.
        wr_reg(0, 8'h34); wr_reg(1, 8'h12);
        expect_addr("R1", 16'h1234);
        rd_reg(2); rd_reg(3);
        // R2/R6: reads through each alias, consecutive addresses.
        for (int p = 4; p < 8; p++) dp_acc(3'(p), 0, 8'(p * 7), 1);
        expect_addr("R6 aliases", 16'h1238);
        // R3/R4: write stalled without ready, then completing.
        dp_acc(5, 1, 8'hA5, 0);
        expect_addr("R4 no ready", 16'h1238);
        dp_acc(5, 1, 8'hA5, 1);
        // R4: low-byte carry.
        wr_reg(0, 8'hFF); wr_reg(1, 8'h00);
        bank_sel = 2'd1;
        dp_acc(6, 0, 8'h11, 1);
        expect_addr("R4 carry", 16'h0100);
        // R5: wrap with bank unchanged.
        wr_reg(0, 8'hFF); wr_reg(1, 8'h7F);
        bank_sel = 2'd2;
        dp_acc(7, 1, 8'h22, 1);
        expect_addr("R5 wrap", 0);
        dp_acc(4, 0, 8'h33, 1);
        chk("R5 bank", mem_addr[16:15], 2);
        // R7: retention through reset.
        wr_reg(0, 8'hC3); wr_reg(1, 8'h5E);
        rst_n = 0; idle(); idle(); rst_n = 1;
        expect_addr("R7 retained", 16'h5EC3);
        // R8/R9/R10: power-down handshake in ISA mode.
        isa_mode = 1;
        wr_reg(1, 8'h80); idle();
        chk("R8 irq set", pd_irq, 1);
        rd_reg(1); chk("R9 not down", last_rdata[7], 0);
        idle(); chk("R8 irq held", pd_irq, 1);
        pd_irq_ack = 1; idle(); pd_irq_ack = 0; idle();
        chk("R8 irq cleared", pd_irq, 0);
        pd_status = 1;
        rd_reg(1); chk("R9 down", last_rdata[7], 1);
        wr_reg(1, 8'h00);
        chk("R10 wake pulse", pd_wake, 1);
        idle(); chk("R10 wake ends", pd_wake, 0);
        // R11: other mode ignores the bit.
        isa_mode = 0;
        wr_reg(1, 8'h80); idle();
        chk("R11 no irq", pd_irq, 0);
        wr_reg(1, 8'h00);
        chk("R11 no wake", pd_wake, 0);
        rd_reg(1); chk("R11 reads 0", last_rdata[7], 0);
        idle();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule